// File: doc/BRIEF.md
# Accumulator Microprocessor Core

This block is a small stored-program processor built around a single accumulator. Program and data share one memory, which the core reaches through one synchronous port: an address, a write data word, a write enable and a read data word that appears one clock after its address. A program counter points at the next instruction. An instruction register holds the word being carried out. The accumulator is the implied source and destination of every arithmetic operation.

Each instruction is 16 bits wide and names one direct memory address. The instruction set has eight operations: load, store, unconditional jump, jump on zero, jump on negative, add, subtract and multiply. A state machine steps through the work of each instruction. FETCH puts the program counter on the bus. DECODE captures the instruction and advances the program counter. MEMREAD fetches an operand, and only the operand-reading operations pass through it. EXECUTE commits the result. A jump whose target is its own address moves the machine into HALT, which raises a flag so that a test harness can inspect memory and the accumulator.

Transitions: FETCH→DECODE always. DECODE→MEMREAD for load, add, subtract and multiply. DECODE→EXECUTE for store and the three jumps. MEMREAD→EXECUTE always. EXECUTE→HALT for an unconditional jump to its own address. EXECUTE→FETCH otherwise. HALT→HALT until reset.

Top module: `accum_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the program counter and the halted flag. In the first cycle after reset is released, the core drives address 0 with the write enable low.
- R2: Instruction format: bits [15:13] hold the opcode and bits [7:0] hold the memory address. The opcodes are 0 load, 1 store, 2 jump, 3 jump-if-zero, 4 jump-if-negative, 5 add, 6 subtract and 7 multiply. Bits [12:8] are ignored.
- R3: Load copies the memory word at the address field into the accumulator.
- R4: Store writes the accumulator to the address field, with the write enable high for exactly one cycle. The core asserts the write enable at no other time.
- R5: Add and subtract combine the accumulator with the memory operand modulo 2^16, and the result goes to the accumulator.
- R6: Multiply places the low 16 bits of the product of the accumulator and the memory operand into the accumulator.
- R7: Jump continues execution at the address field.
- R8: Jump-if-zero goes to the address field when the accumulator is 0. Otherwise execution continues at the next address.
- R9: Jump-if-negative goes to the address field when accumulator bit 15 is 1. Otherwise execution continues at the next address.
- R10: A jump whose target equals its own address raises halted. Halted then stays high until reset, the accumulator stays constant and no further writes occur.
- R11: Load, add, subtract and multiply take 4 cycles. Store and the jumps take 3 cycles. halted is high 3 cycles after the start of the final self-jump's fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| halted | output | 1 | High once a self-jump has executed |
| acc_value | output | 16 | Current accumulator contents |

## Verification
The assertions take for granted that the memory returns the word for the previous cycle's address, with nothing added between. Nothing from the core is checked against the memory's contents in the same cycle. They also take for granted that reset is held high from time zero through at least one clock edge. The bench uses a memory model that registers its read word on every edge. Each program is loaded while the core sits halted or in reset, and every scenario starts with reset asserted for several edges. Every program ends in a self-jump, so the core always comes to rest in HALT.

// File: rtl/accum_pkg.sv
package accum_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_JMP   = 3'd2,
        OP_JMPZ  = 3'd3,
        OP_JMPN  = 3'd4,
        OP_ADD   = 3'd5,
        OP_SUB   = 3'd6,
        OP_MUL   = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEMREAD,
        ST_EXECUTE,
        ST_HALT
    } state_e;

    function automatic logic reads_operand(input opcode_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

endpackage

// File: rtl/accum_alu.sv
module accum_alu
    import accum_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   result
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] product;

    assign product = {{DATA_W{1'b0}}, acc} * {{DATA_W{1'b0}}, operand};

    always_comb begin
        case (op)
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_MUL:  result = product[DATA_W-1:0];
            default: result = operand;
        endcase
    end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
    import accum_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e rd_op,
    input  opcode_e ir_op,
    input  logic    acc_zero,
    input  logic    acc_neg,
    input  logic    self_jump,
    output logic    ir_load,
    output logic    pc_inc,
    output logic    pc_load,
    output logic    acc_load,
    output logic    mem_we,
    output logic    addr_from_ir,
    output logic    halted
);

    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   state_d = ST_DECODE;
            ST_DECODE:  state_d = reads_operand(rd_op) ? ST_MEMREAD : ST_EXECUTE;
            ST_MEMREAD: state_d = ST_EXECUTE;
            ST_EXECUTE: state_d = (ir_op == OP_JMP && self_jump) ? ST_HALT : ST_FETCH;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        ir_load      = 1'b0;
        pc_inc       = 1'b0;
        pc_load      = 1'b0;
        acc_load     = 1'b0;
        mem_we       = 1'b0;
        addr_from_ir = 1'b0;
        halted       = 1'b0;
        unique case (state_q)
            ST_FETCH: ;
            ST_DECODE: begin
                ir_load = 1'b1;
                pc_inc  = 1'b1;
            end
            ST_MEMREAD: addr_from_ir = 1'b1;
            ST_EXECUTE: begin
                unique case (ir_op)
                    OP_LOAD, OP_ADD, OP_SUB, OP_MUL: acc_load = 1'b1;
                    OP_STORE: begin
                        addr_from_ir = 1'b1;
                        mem_we       = 1'b1;
                    end
                    OP_JMP:  pc_load = 1'b1;
                    OP_JMPZ: pc_load = acc_zero;
                    OP_JMPN: pc_load = acc_neg;
                    default: ;
                endcase
            end
            ST_HALT: halted = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/accum_core.sv
module accum_core
    import accum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] acc_value
);

    localparam int OPC_LSB = DATA_W - OPC_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_res;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] cur_pc;
    opcode_e           ir_op;
    opcode_e           rd_op;

    logic ir_load, pc_inc, pc_load, acc_load, addr_from_ir;

    assign ir_op   = opcode_e'(ir_q[DATA_W-1:OPC_LSB]);
    assign rd_op   = opcode_e'(mem_rdata[DATA_W-1:OPC_LSB]);
    assign ir_addr = ir_q[ADDR_W-1:0];
    assign cur_pc  = pc_q - ADDR_W'(1);

    accum_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rd_op        (rd_op),
        .ir_op        (ir_op),
        .acc_zero     (acc_q == '0),
        .acc_neg      (acc_q[DATA_W-1]),
        .self_jump    (ir_addr == cur_pc),
        .ir_load      (ir_load),
        .pc_inc       (pc_inc),
        .pc_load      (pc_load),
        .acc_load     (acc_load),
        .mem_we       (mem_we),
        .addr_from_ir (addr_from_ir),
        .halted       (halted)
    );

    accum_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (ir_op),
        .acc     (acc_q),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ir_load)      ir_q <= mem_rdata;
            if (pc_load)      pc_q <= ir_addr;
            else if (pc_inc)  pc_q <= pc_q + ADDR_W'(1);
            if (acc_load)     acc_q <= alu_res;
        end
    end

    assign mem_addr  = addr_from_ir ? ir_addr : pc_q;
    assign mem_wdata = acc_q;
    assign acc_value = acc_q;

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input logic [DATA_W-1:0] acc_value
);

    AST_RESET_START: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (mem_addr == '0 && !mem_we && !halted && acc_value == '0)); // R1
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R4
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) halted |-> !mem_we); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R10
    AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(acc_value)); // R10

endmodule

bind accum_core accum_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .halted    (halted),
    .acc_value (acc_value)
);

// File: tb/accum_core_bench.sv
`timescale 1ns/1ps
module accum_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;
    logic [15:0] acc_value;

    logic [15:0] mem [256];
    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    accum_core u_accum_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .acc_value (acc_value)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (!rst && mem_we) wr_cnt = wr_cnt + 1;
    end

    function automatic logic [15:0] ins(input logic [2:0] op, input logic [7:0] a);
        return {op, 5'b0, a};
    endfunction

    task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_cnt = 0;
        rst = 1'b0;
    endtask

    task automatic run_prog(input string tag, input int exp_cycles, input int exp_writes);
        int cyc = 0;
        do_reset();
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        check_eq("R10", {tag, " halted"}, halted, 1);
        check_eq("R11", {tag, " cycles"}, cyc, exp_cycles);
        check_eq("R4", {tag, " write count"}, wr_cnt, exp_writes);
    endtask

    // R1: reset state and first fetch
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "halted in reset", halted, 0);
        check_eq("R1", "acc in reset", acc_value, 0);
        rst = 1'b0;
        check_eq("R1", "first fetch addr", mem_addr, 0);
        check_eq("R1", "first fetch we", mem_we, 0);
    endtask

    // R2 R3 R4 R7: load/store with junk in bits 12:8, forward jump
    task automatic t_loadstore_jump();
        clear_mem();
        mem[0] = {3'd0, 5'h15, 8'd60};
        mem[1] = {3'd1, 5'h0A, 8'd61};
        mem[2] = {3'd2, 5'h1F, 8'd5};
        mem[3] = ins(3'd1, 8'd62);
        mem[4] = ins(3'd2, 8'd4);
        mem[5] = {3'd2, 5'h11, 8'd5};
        mem[60] = 16'hBEEF;
        mem[62] = 16'h5555;
        run_prog("ldst", 13, 1);
        check_eq("R3", "acc after load", acc_value, 16'hBEEF);
        check_eq("R2", "store with junk bits", mem[61], 16'hBEEF);
        check_eq("R7", "skipped store untouched", mem[62], 16'h5555);
    endtask

    // R5 R6: arithmetic with wraparound
    task automatic t_arith();
        logic [15:0] a, e30, e31, e32, e33, e34;
        logic [31:0] p;
        clear_mem();
        mem[0]  = ins(3'd0, 8'd20);
        mem[1]  = ins(3'd5, 8'd21);
        mem[2]  = ins(3'd1, 8'd30);
        mem[3]  = ins(3'd6, 8'd22);
        mem[4]  = ins(3'd1, 8'd31);
        mem[5]  = ins(3'd7, 8'd23);
        mem[6]  = ins(3'd1, 8'd32);
        mem[7]  = ins(3'd0, 8'd24);
        mem[8]  = ins(3'd6, 8'd21);
        mem[9]  = ins(3'd1, 8'd33);
        mem[10] = ins(3'd7, 8'd25);
        mem[11] = ins(3'd1, 8'd34);
        mem[12] = ins(3'd2, 8'd12);
        mem[20] = 16'h7FFF;
        mem[21] = 16'h0001;
        mem[22] = 16'h0003;
        mem[23] = 16'h0123;
        mem[24] = 16'h0000;
        mem[25] = 16'hFFFF;
        a = 16'h7FFF + 16'h0001;          e30 = a;
        a = a - 16'h0003;                 e31 = a;
        p = {16'h0, a} * 32'h0123;        e32 = p[15:0];
        a = 16'h0000 - 16'h0001;          e33 = a;
        p = {16'h0, a} * 32'h0000FFFF;    e34 = p[15:0];
        run_prog("arith", 46, 5);
        check_eq("R5", "add overflow", mem[30], e30);
        check_eq("R5", "subtract", mem[31], e31);
        check_eq("R6", "multiply low half", mem[32], e32);
        check_eq("R5", "subtract below zero", mem[33], e33);
        check_eq("R6", "multiply negatives", mem[34], e34);
        check_eq("R6", "final acc", acc_value, e34);
    endtask

    // R8 R9: conditional branches taken and not taken
    task automatic t_branch();
        clear_mem();
        mem[0]  = ins(3'd0, 8'd40);
        mem[1]  = ins(3'd3, 8'd4);
        mem[2]  = ins(3'd1, 8'd50);
        mem[3]  = ins(3'd2, 8'd3);
        mem[4]  = ins(3'd0, 8'd41);
        mem[5]  = ins(3'd3, 8'd8);
        mem[6]  = ins(3'd1, 8'd51);
        mem[7]  = ins(3'd4, 8'd20);
        mem[8]  = ins(3'd0, 8'd42);
        mem[9]  = ins(3'd4, 8'd12);
        mem[10] = ins(3'd1, 8'd52);
        mem[11] = ins(3'd2, 8'd11);
        mem[12] = ins(3'd1, 8'd53);
        mem[13] = ins(3'd2, 8'd13);
        mem[40] = 16'h0000;
        mem[41] = 16'h0005;
        mem[42] = 16'h8001;
        mem[50] = 16'hAAAA;
        mem[51] = 16'hAAAA;
        mem[52] = 16'hAAAA;
        mem[53] = 16'hAAAA;
        run_prog("branch", 33, 2);
        check_eq("R8", "jumpz taken skips store", mem[50], 16'hAAAA);
        check_eq("R8", "jumpz not taken falls through", mem[51], 16'h0005);
        check_eq("R9", "jumpn taken skips store", mem[52], 16'hAAAA);
        check_eq("R9", "jumpn target reached", mem[53], 16'h8001);
    endtask

    // R10: halt holds
    task automatic t_halt_hold();
        logic [15:0] acc_before;
        int w_before;
        acc_before = acc_value;
        w_before = wr_cnt;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check_eq("R10", "halted stays", halted, 1);
        check_eq("R10", "acc stable in halt", acc_value, acc_before);
        check_eq("R10", "no writes in halt", wr_cnt, w_before);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clear_mem();
        t_reset();
        t_loadstore_jump();
        t_arith();
        t_halt_hold();
        t_branch();
        t_halt_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule